// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit holds the two special result registers, HI and LO, that sit beside the integer pipeline of a 32-bit RISC core. Together they form one 64-bit accumulator, with HI as the upper word. The pipeline presents a decoded instruction as a one-cycle `start` pulse. The pulse carries a group select (`sp2`: 0 for the primary register-register group, 1 for the secondary group), the 6-bit function field and the two source operands `rs` and `rt`. Multiplies, multiply-accumulates and divides run in the background while `busy` is high. Moves into HI and LO finish in one cycle.

Reads of HI or LO come back on `rd_data` with a one-cycle `rd_valid` strobe. If a read arrives while an operation is still running, the unit holds it and answers with the updated value in the cycle in which `busy` falls. The three-operand multiply returns the low word of its product on the same read port and does not change HI or LO. Hazard detection and exception signalling are left to the surrounding pipeline.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After reset, HI and LO read as zero, and `busy` and `rd_valid` are low.
- R2: With sp2=0, function 0x18 (signed) or 0x19 (unsigned) forms the 64-bit product rs*rt. HI receives bits 63:32 and LO receives bits 31:0. `busy` stays high for exactly MUL_LAT cycles after the accepting edge.
- R3: With sp2=0, function 0x1A (signed) or 0x1B (unsigned) writes the quotient rs/rt to LO and the remainder to HI. The quotient is truncated toward zero and the remainder takes the sign of rs. The most negative dividend divided by -1 gives quotient 0x80000000 and remainder 0. `busy` stays high for DATA_W+1 cycles.
- R4: A divide with rt=0 ends with the same latency as any other divide and leaves LO all ones and HI equal to rs.
- R5: With sp2=0, function 0x11 copies rs into HI and function 0x13 copies rs into LO at the accepting edge. Function 0x10 returns HI and function 0x12 returns LO on `rd_data`, with `rd_valid` high in the cycle after the accepting edge when the unit is idle.
- R6: With sp2=1, function 0x00 (signed) or 0x01 (unsigned) adds the 64-bit product rs*rt to {HI,LO} and writes the sum back, modulo 2^64.
- R7: With sp2=1, function 0x04 (signed) or 0x05 (unsigned) subtracts the 64-bit product rs*rt from {HI,LO} and writes the difference back, modulo 2^64.
- R8: With sp2=1, function 0x02 returns the low 32 bits of the signed product on `rd_data`, with `rd_valid` high in the cycle `busy` falls after MUL_LAT cycles. HI and LO stay unchanged.
- R9: A read of HI or LO issued while `busy` is high is held. It is answered with the post-operation value, and `rd_valid` is high in the first cycle in which `busy` is low.
- R10: While `busy` is high, a start of any non-read operation has no effect. A function code outside R2 to R8 has no effect at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle operation request |
| sp2 | input | 1 | Function group select: 0 primary, 1 secondary |
| funct | input | 6 | Function field of the instruction |
| rs | input | DATA_W | First source operand |
| rt | input | DATA_W | Second source operand |
| busy | output | 1 | A multiply or divide is in progress |
| rd_valid | output | 1 | One-cycle strobe qualifying rd_data |
| rd_data | output | DATA_W | HI, LO or three-operand product returned to the pipeline |

## Verification
The in-line properties check the following on every cycle:
- HI and LO cannot move while an operation is in flight, except at its completing edge.
- The three-operand multiply never writes HI or LO.
- A held read exists only while the unit is busy.
- Each engine produces a single completion pulse, and the two engines never complete together.
- The divider's iteration count stays within its bound.

The arithmetic itself can only be shown by the directed scenarios. These cover signed and unsigned products, accumulate and subtract wrap-around, the sign rules of division, the divide-by-zero value, the most-negative-over-minus-one case, the exact busy latencies, and the value a held read returns.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

    typedef enum logic [3:0] {
        K_NONE,
        K_MFHI,
        K_MTHI,
        K_MFLO,
        K_MTLO,
        K_MULT,
        K_MULTU,
        K_DIV,
        K_DIVU,
        K_MADD,
        K_MADDU,
        K_MSUB,
        K_MSUBU,
        K_MUL
    } hl_kind_e;

    // Map group select and function field onto an internal operation kind
    function automatic hl_kind_e hl_decode(input logic sp2, input logic [5:0] fn);
        hl_kind_e k;
        k = K_NONE;
        if (!sp2) begin
            case (fn)
                6'h10:   k = K_MFHI;
                6'h11:   k = K_MTHI;
                6'h12:   k = K_MFLO;
                6'h13:   k = K_MTLO;
                6'h18:   k = K_MULT;
                6'h19:   k = K_MULTU;
                6'h1A:   k = K_DIV;
                6'h1B:   k = K_DIVU;
                default: k = K_NONE;
            endcase
        end else begin
            case (fn)
                6'h00:   k = K_MADD;
                6'h01:   k = K_MADDU;
                6'h02:   k = K_MUL;
                6'h04:   k = K_MSUB;
                6'h05:   k = K_MSUBU;
                default: k = K_NONE;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/hilo_mul_seq.sv
module hilo_mul_seq #(
    parameter int DW  = 32,
    parameter int LAT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            sgn,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic            done,
    output logic [2*DW-1:0] prod
);
    localparam int PW = 2 * DW;
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LAT - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        logic          sgn;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } mul_st_t;

    mul_st_t q, d;
    logic [PW-1:0] ax, bx;

    always_comb begin
        d = q;
        if (start) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.sgn    = sgn;
            d.a      = a;
            d.b      = b;
        end else if (q.active) begin
            if (q.cnt == LAST) d.active = 1'b0;
            else               d.cnt    = q.cnt + 1'b1;
        end
    end

    // Operand extension to full product width: low 2*DW bits are exact
    always_comb begin
        ax   = {{DW{q.sgn & q.a[DW-1]}}, q.a};
        bx   = {{DW{q.sgn & q.b[DW-1]}}, q.b};
        prod = ax * bx;
        done = q.active && (q.cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: completion is a single pulse per operation
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/hilo_div_seq.sv
module hilo_div_seq #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          sgn,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic          done,
    output logic [DW-1:0] quo,
    output logic [DW-1:0] rem
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    typedef struct packed {
        logic          active;
        logic          done;
        logic [CW-1:0] cnt;
        logic [DW-1:0] rem;
        logic [DW-1:0] quo;
        logic [DW-1:0] dvs;
        logic [DW-1:0] orig;
        logic          neg_q;
        logic          neg_r;
        logic          zero;
    } div_st_t;

    div_st_t q, d;
    logic [DW:0] sh, diff;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        sh     = {q.rem, q.quo[DW-1]};
        diff   = sh - {1'b0, q.dvs};
        if (start) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.rem    = '0;
            d.quo    = (sgn && a[DW-1]) ? (~a + 1'b1) : a;
            d.dvs    = (sgn && b[DW-1]) ? (~b + 1'b1) : b;
            d.orig   = a;
            d.neg_q  = sgn && (a[DW-1] ^ b[DW-1]);
            d.neg_r  = sgn && a[DW-1];
            d.zero   = (b == '0);
        end else if (q.active) begin
            // Restoring step: one quotient bit per clock
            if (!diff[DW]) begin
                d.rem = diff[DW-1:0];
                d.quo = {q.quo[DW-2:0], 1'b1};
            end else begin
                d.rem = sh[DW-1:0];
                d.quo = {q.quo[DW-2:0], 1'b0};
            end
            if (q.cnt == LAST) begin
                d.active = 1'b0;
                d.done   = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_comb begin
        done = q.done;
        if (q.zero) begin
            quo = '1;
            rem = q.orig;
        end else begin
            quo = q.neg_q ? (~q.quo + 1'b1) : q.quo;
            rem = q.neg_r ? (~q.rem + 1'b1) : q.rem;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3: completion arrives once and iteration never runs past the last bit
    a_r3_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    a_r3_no_iter_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !q.active);

endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit
    import hilo_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int MUL_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sp2,
    input  logic [5:0]        funct,
    input  logic [DATA_W-1:0] rs,
    input  logic [DATA_W-1:0] rt,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DW = DATA_W;
    localparam int AW = 2 * DATA_W;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        logic          busy;
        hl_kind_e      kind;
        logic          pend;
        logic          pend_hi;
        logic          rd_valid;
        logic [DW-1:0] rd_data;
    } top_st_t;

    top_st_t q, d;

    hl_kind_e      kind_in;
    logic          accept, is_read, late_rd, pend_now, pend_hi_now;
    logic          mul_go, div_go, mul_sgn, div_sgn, fin;
    logic          mul_done, div_done;
    logic [AW-1:0] mul_prod, accv, res64;
    logic [DW-1:0] div_quo, div_rem;

    hilo_mul_seq #(.DW(DW), .LAT(MUL_LAT)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_go),
        .sgn   (mul_sgn),
        .a     (rs),
        .b     (rt),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    hilo_div_seq #(.DW(DW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_go),
        .sgn   (div_sgn),
        .a     (rs),
        .b     (rt),
        .done  (div_done),
        .quo   (div_quo),
        .rem   (div_rem)
    );

    // Request decode and engine launch
    always_comb begin
        kind_in     = hl_decode(sp2, funct);
        accept      = start && !q.busy;
        is_read     = (kind_in == K_MFHI) || (kind_in == K_MFLO);
        mul_go      = accept && (kind_in inside {K_MULT, K_MULTU, K_MADD, K_MADDU,
                                                 K_MSUB, K_MSUBU, K_MUL});
        div_go      = accept && (kind_in inside {K_DIV, K_DIVU});
        mul_sgn     = kind_in inside {K_MULT, K_MADD, K_MSUB, K_MUL};
        div_sgn     = (kind_in == K_DIV);
        fin         = mul_done || div_done;
        late_rd     = start && q.busy && is_read && !q.pend;
        pend_now    = q.pend || late_rd;
        pend_hi_now = q.pend ? q.pend_hi : (kind_in == K_MFHI);
    end

    // Result of the operation in flight, against the current accumulator
    always_comb begin
        accv  = {q.hi, q.lo};
        res64 = accv;
        case (q.kind)
            K_MULT, K_MULTU: res64 = mul_prod;
            K_MADD, K_MADDU: res64 = accv + mul_prod;
            K_MSUB, K_MSUBU: res64 = accv - mul_prod;
            K_DIV, K_DIVU:   res64 = {div_rem, div_quo};
            default:         res64 = accv;
        endcase
    end

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        if (accept) begin
            case (kind_in)
                K_MTHI: d.hi = rs;
                K_MTLO: d.lo = rs;
                K_MFHI: begin
                    d.rd_valid = 1'b1;
                    d.rd_data  = q.hi;
                end
                K_MFLO: begin
                    d.rd_valid = 1'b1;
                    d.rd_data  = q.lo;
                end
                K_NONE: d = d;
                default: begin
                    d.busy = 1'b1;
                    d.kind = kind_in;
                end
            endcase
        end else if (q.busy) begin
            if (late_rd) begin
                d.pend    = 1'b1;
                d.pend_hi = (kind_in == K_MFHI);
            end
            if (fin) begin
                if (q.kind == K_MUL) begin
                    // Product low word takes the port; a held read follows next cycle
                    d.rd_valid = 1'b1;
                    d.rd_data  = mul_prod[DW-1:0];
                    d.kind     = K_NONE;
                    d.busy     = pend_now;
                end else begin
                    d.hi   = res64[AW-1:DW];
                    d.lo   = res64[DW-1:0];
                    d.busy = 1'b0;
                    d.pend = 1'b0;
                    if (pend_now) begin
                        d.rd_valid = 1'b1;
                        d.rd_data  = pend_hi_now ? res64[AW-1:DW] : res64[DW-1:0];
                    end
                end
            end else if (q.kind == K_NONE) begin
                d.busy     = 1'b0;
                d.pend     = 1'b0;
                d.rd_valid = 1'b1;
                d.rd_data  = q.pend_hi ? q.hi : q.lo;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign rd_valid = q.rd_valid;
    assign rd_data  = q.rd_data;

    // R10: accumulator frozen while busy, except at the completing edge
    a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !fin) |=> ($stable(q.hi) && $stable(q.lo)));

    // R8: the three-operand multiply never writes HI or LO
    a_r8_mul_keeps_hilo: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.kind == K_MUL) |=> ($stable(q.hi) && $stable(q.lo)));

    // R9: a held read only exists while an operation is outstanding
    a_r9_pend_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend |-> q.busy);

    // R2 / R3: the two engines never complete in the same cycle
    a_r2_one_engine: assert property (@(posedge clk) disable iff (!rst_n)
        !(mul_done && div_done));

endmodule

// File: tb/sim_hilo_muldiv_unit.sv
module sim_hilo_muldiv_unit;
    localparam int DW  = 32;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          sp2 = 1'b0;
    logic [5:0]    funct = '0;
    logic [DW-1:0] rs = '0;
    logic [DW-1:0] rt = '0;
    logic          busy;
    logic          rd_valid;
    logic [DW-1:0] rd_data;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hilo_muldiv_unit #(.DATA_W(DW), .MUL_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sp2(sp2), .funct(funct),
        .rs(rs), .rt(rt), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one start pulse; returns on the negedge after the accepting edge
    task automatic issue(input bit g, input logic [5:0] f, input logic [DW-1:0] a, input logic [DW-1:0] b);
        @(negedge clk);
        start = 1'b1; sp2 = g; funct = f; rs = a; rt = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(output int n, output bit rv, output logic [DW-1:0] rdv);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        rv  = rd_valid;
        rdv = rd_data;
    endtask

    task automatic read_hl(input bit hi_sel, output logic [DW-1:0] v, output bit ok);
        issue(1'b0, hi_sel ? 6'h10 : 6'h12, '0, '0);
        ok = rd_valid;
        v  = rd_data;
    endtask

    task automatic check_acc(input string req, input logic [63:0] exp);
        logic [DW-1:0] h, l;
        bit v1, v2;
        read_hl(1'b1, h, v1);
        read_hl(1'b0, l, v2);
        chk(v1 && v2 && ({h, l} == exp), req, {h, l}, exp);
    endtask

    task automatic set_acc(input logic [63:0] v);
        issue(1'b0, 6'h11, v[63:32], '0);
        issue(1'b0, 6'h13, v[31:0], '0);
    endtask

    function automatic logic [63:0] prod64(input bit s, input logic [DW-1:0] a, input logic [DW-1:0] b);
        if (s) return 64'(longint'($signed(a)) * longint'($signed(b)));
        return {32'b0, a} * {32'b0, b};
    endfunction

    function automatic logic [63:0] div64(input bit s, input logic [DW-1:0] a, input logic [DW-1:0] b);
        longint sa, sb, qq, rr;
        if (b == '0) return {a, 32'hFFFF_FFFF};
        if (s) begin
            sa = longint'($signed(a)); sb = longint'($signed(b));
        end else begin
            sa = longint'({32'b0, a}); sb = longint'({32'b0, b});
        end
        qq = sa / sb;
        rr = sa % sb;
        return {rr[31:0], qq[31:0]};
    endfunction

    // Run one accumulator-writing operation and check latency and result
    task automatic run_op(input string req, input bit g, input logic [5:0] f,
                          input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic [63:0] exp, input int lat);
        int n; bit rv; logic [DW-1:0] rdv;
        issue(g, f, a, b);
        wait_idle(n, rv, rdv);
        chk(n == lat, {req, " latency"}, 64'(n), 64'(lat));
        check_acc(req, exp);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v; bit ok;
        chk(busy == 1'b0 && rd_valid == 1'b0, "R1 busy/rd_valid", {busy, rd_valid}, 0);
        read_hl(1'b1, v, ok);
        chk(ok && v == 0, "R1 HI", v, 0);
        read_hl(1'b0, v, ok);
        chk(ok && v == 0, "R1 LO", v, 0);
    endtask

    task automatic t_move();
        set_acc(64'h1234_5678_9ABC_DEF0);
        check_acc("R5 move to/from", 64'h1234_5678_9ABC_DEF0);
    endtask

    task automatic t_mult();
        run_op("R2 mult signed", 0, 6'h18, 32'hFFFF_FFFD, 32'd7, prod64(1, 32'hFFFF_FFFD, 32'd7), LAT);
        run_op("R2 multu", 0, 6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, prod64(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF), LAT);
        run_op("R2 mult neg*neg", 0, 6'h18, 32'h8000_0000, 32'h8000_0000, prod64(1, 32'h8000_0000, 32'h8000_0000), LAT);
    endtask

    task automatic t_div();
        run_op("R3 div signed -7/2", 0, 6'h1A, 32'hFFFF_FFF9, 32'd2, div64(1, 32'hFFFF_FFF9, 32'd2), DW + 1);
        run_op("R3 div signed 7/-2", 0, 6'h1A, 32'd7, 32'hFFFF_FFFE, div64(1, 32'd7, 32'hFFFF_FFFE), DW + 1);
        run_op("R3 divu", 0, 6'h1B, 32'hFFFF_FFF9, 32'd10, div64(0, 32'hFFFF_FFF9, 32'd10), DW + 1);
        run_op("R3 min/-1", 0, 6'h1A, 32'h8000_0000, 32'hFFFF_FFFF, {32'h0, 32'h8000_0000}, DW + 1);
    endtask

    task automatic t_divzero();
        run_op("R4 div by zero signed", 0, 6'h1A, 32'hFFFF_FF00, 32'd0, {32'hFFFF_FF00, 32'hFFFF_FFFF}, DW + 1);
        run_op("R4 divu by zero", 0, 6'h1B, 32'd12345, 32'd0, {32'd12345, 32'hFFFF_FFFF}, DW + 1);
    endtask

    task automatic t_madd();
        logic [63:0] acc = 64'h0000_0001_FFFF_FFFF;
        set_acc(acc);
        acc = acc + prod64(1, 32'hFFFF_FFFD, 32'd7);
        run_op("R6 madd signed", 1, 6'h00, 32'hFFFF_FFFD, 32'd7, acc, LAT);
        acc = acc + prod64(0, 32'hFFFF_FFFF, 32'd2);
        run_op("R6 maddu", 1, 6'h01, 32'hFFFF_FFFF, 32'd2, acc, LAT);
        set_acc(64'hFFFF_FFFF_FFFF_FFFF);
        run_op("R6 maddu wrap", 1, 6'h01, 32'd1, 32'd1, 64'h0, LAT);
    endtask

    task automatic t_msub();
        logic [63:0] acc = 64'h0000_0000_0000_0010;
        set_acc(acc);
        acc = acc - prod64(1, 32'hFFFF_FFFB, 32'd3);
        run_op("R7 msub signed", 1, 6'h04, 32'hFFFF_FFFB, 32'd3, acc, LAT);
        acc = acc - prod64(0, 32'hFFFF_FFFB, 32'd3);
        run_op("R7 msubu", 1, 6'h05, 32'hFFFF_FFFB, 32'd3, acc, LAT);
    endtask

    task automatic t_mul();
        int n; bit rv; logic [DW-1:0] rdv;
        set_acc(64'hAAAA_BBBB_CCCC_DDDD);
        issue(1, 6'h02, 32'hFFFF_FFFB, 32'd6);
        wait_idle(n, rv, rdv);
        chk(n == LAT, "R8 mul latency", 64'(n), 64'(LAT));
        chk(rv && rdv == 32'hFFFF_FFE2, "R8 mul low word", {rv, rdv}, {1'b1, 32'hFFFF_FFE2});
        check_acc("R8 mul keeps HI/LO", 64'hAAAA_BBBB_CCCC_DDDD);
    endtask

    task automatic t_pending();
        int n; bit rv; logic [DW-1:0] rdv;
        logic [63:0] exp = prod64(0, 32'h0001_0003, 32'h0002_0005);
        issue(0, 6'h19, 32'h0001_0003, 32'h0002_0005);
        chk(busy == 1'b1, "R9 busy after multu", busy, 1);
        issue(0, 6'h12, '0, '0);
        chk(rd_valid == 1'b0, "R9 no early answer", rd_valid, 0);
        wait_idle(n, rv, rdv);
        chk(rv && rdv == exp[31:0], "R9 held read value", {rv, rdv}, {1'b1, exp[31:0]});
        issue(0, 6'h1B, 32'd100, 32'd7);
        issue(0, 6'h10, '0, '0);
        wait_idle(n, rv, rdv);
        chk(rv && rdv == 32'd2, "R9 held HI after divu", {rv, rdv}, {1'b1, 32'd2});
    endtask

    task automatic t_ignore();
        int n; bit rv; logic [DW-1:0] rdv;
        issue(0, 6'h1B, 32'd50, 32'd8);
        issue(0, 6'h13, 32'h1234_5678, '0);
        issue(0, 6'h11, 32'h1111_1111, '0);
        issue(0, 6'h18, 32'd9, 32'd9);
        wait_idle(n, rv, rdv);
        check_acc("R10 writes during busy ignored", {32'd2, 32'd6});
        issue(0, 6'h14, 32'hDEAD_BEEF, 32'd3);
        chk(busy == 1'b0 && rd_valid == 1'b0, "R10 unknown code idle", {busy, rd_valid}, 0);
        issue(1, 6'h18, 32'hDEAD_BEEF, 32'd3);
        chk(busy == 1'b0 && rd_valid == 1'b0, "R10 unknown group-1 code idle", {busy, rd_valid}, 0);
        check_acc("R10 unknown codes keep HI/LO", {32'd2, 32'd6});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_move();
        t_mult();
        t_div();
        t_divzero();
        t_madd();
        t_msub();
        t_mul();
        t_pending();
        t_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule